// File: doc/BRIEF.md
# Sector Erase Accumulation Window Timer

This block gathers sector erase requests into a pending set while a restartable time-out is running. The first sector erase command opens an acceptance window. Each later sector erase command that arrives inside the window adds its sector and restarts the full time-out. When the time-out runs out without a new command, the window closes, the status bit goes to 1 and the erase begins. The erase is modelled here as a fixed countdown of microsecond ticks. While it runs, every command except erase suspend is ignored. A suspend is passed on as a one-cycle pulse.

The controller is a three-state machine. IDLE moves to COLLECT on a sector erase command. COLLECT stays in COLLECT on every further sector erase command, and each one restarts the window. COLLECT moves to ERASE when the window count expires. ERASE returns to IDLE when the erase count expires. A synchronous reset sends any state to IDLE. Time is counted only on cycles where `us_tick` is high. The command opcodes are 2'b00 none, 2'b01 sector erase, 2'b10 erase suspend and 2'b11 chip erase. Chip erase is outside this block and has no effect on it.

Top module: `erase_window_ctrl`

## Requirements
- R1: While `rst` is high at a clock edge, `win_closed`, `busy`, `erase_start` and `susp_out` are 0 after that edge, and `pend_mask` is 0.
- R2: In IDLE, a sector erase command (opcode 2'b01) with index k sets bit k of `pend_mask` (bit position equals the sector index). It drives `busy` to 1 and leaves `win_closed` at 0 from the next cycle.
- R3: The window closes on the WIN_US-th tick (default 80) after the last accepted sector erase command. Cycles without a tick do not count. On that cycle `win_closed` rises and `erase_start` is high for exactly one cycle.
- R4: A sector erase command inside the open window ORs its sector into the mask and restarts the full time-out. Commands spaced 49 ticks apart therefore never let the window close, because WIN_US exceeds 50.
- R5: A sector erase command whose sector is already pending leaves `pend_mask` unchanged but still restarts the time-out.
- R6: While `win_closed` is 1, sector erase (2'b01) and chip erase (2'b11) commands change neither `pend_mask` nor `win_closed`, and they do not shorten or lengthen the erase.
- R7: An erase suspend command (2'b10) while `win_closed` is 1 gives a one-cycle `susp_out` pulse on the next cycle. A suspend in IDLE gives no pulse.
- R8: The erase ends on the ERASE_US-th tick (default 16) after `erase_start`. After that edge, `pend_mask`, `busy` and `win_closed` are all 0.
- R9: A chip erase command in IDLE does not open a window. `busy`, `win_closed` and `pend_mask` stay 0.
- R10: A reset in COLLECT clears the mask and the window count. No erase starts afterwards, however many ticks follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command strobe, one cycle per command |
| cmd_op | input | 2 | Opcode: 00 none, 01 sector erase, 10 suspend, 11 chip erase |
| cmd_sector | input | $clog2(NUM_SECT) | Sector index for a sector erase command |
| us_tick | input | 1 | One-cycle pulse per microsecond |
| win_closed | output | 1 | 0 while the window is open or idle, 1 once the erase has begun |
| pend_mask | output | NUM_SECT | One bit per pending sector |
| erase_start | output | 1 | One-cycle pulse when the window closes |
| busy | output | 1 | High in COLLECT and ERASE |
| susp_out | output | 1 | One-cycle pulse for a suspend accepted during the erase |

## Verification
A wrong state shows at the ports within one cycle, because `busy` and `win_closed` are registered straight from the next state. COLLECT reads busy=1 and closed=0, ERASE reads 1 and 1, and IDLE reads 0 and 0. A window counter that is off by one shows as `erase_start` firing one tick early or late. The bench counts ticks to the exact boundary, 79 and then 80, to catch this. A mask that takes a command after the window has closed differs at the port in the very next cycle.

// File: rtl/ewc_pkg.sv
package ewc_pkg;
    typedef enum logic [1:0] {
        OP_NONE       = 2'b00,
        OP_SECT_ERASE = 2'b01,
        OP_SUSPEND    = 2'b10,
        OP_CHIP_ERASE = 2'b11
    } cmd_op_e;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'b00,
        ST_COLLECT = 2'b01,
        ST_ERASE   = 2'b10
    } ewc_state_e;
endpackage

// File: rtl/ewc_tick_timer.sv
module ewc_tick_timer #(
    parameter int LEN = 80,
    localparam int CW = $clog2(LEN + 1)
) (
    input  logic clk,
    input  logic rst,
    input  logic load,
    input  logic tick,
    output logic expire
);
    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)
            cnt_q <= '0;
        else if (load)
            cnt_q <= CW'(LEN);
        else if (tick && cnt_q != '0)
            cnt_q <= cnt_q - 1'b1;
    end

    // The last tick of a running count.
    assign expire = tick && (cnt_q == CW'(1));
endmodule

// File: rtl/ewc_sector_set.sv
module ewc_sector_set #(
    parameter int NUM_SECT = 8,
    localparam int IDX_W = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                add,
    input  logic [IDX_W-1:0]    idx,
    input  logic                clr,
    output logic [NUM_SECT-1:0] mask
);
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_bit
        always_ff @(posedge clk) begin
            if (rst || clr)
                mask[i] <= 1'b0;
            else if (add && idx == IDX_W'(i))
                mask[i] <= 1'b1;
        end
    end
endmodule

// File: rtl/erase_window_ctrl.sv
module erase_window_ctrl #(
    parameter int NUM_SECT = 8,
    parameter int WIN_US   = 80,
    parameter int ERASE_US = 16,
    localparam int IDX_W   = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                cmd_valid,
    input  logic [1:0]          cmd_op,
    input  logic [IDX_W-1:0]    cmd_sector,
    input  logic                us_tick,
    output logic                win_closed,
    output logic [NUM_SECT-1:0] pend_mask,
    output logic                erase_start,
    output logic                busy,
    output logic                susp_out
);
    import ewc_pkg::*;

    ewc_state_e state_q, state_d;
    cmd_op_e    op;
    logic       se_cmd, su_cmd;
    logic       win_load, win_exp;
    logic       ers_load, ers_exp;
    logic       mask_add, mask_clr;

    assign op     = cmd_op_e'(cmd_op);
    assign se_cmd = cmd_valid && (op == OP_SECT_ERASE);
    assign su_cmd = cmd_valid && (op == OP_SUSPEND);

    ewc_tick_timer #(.LEN(WIN_US)) u_win (
        .clk(clk), .rst(rst), .load(win_load), .tick(us_tick), .expire(win_exp)
    );

    ewc_tick_timer #(.LEN(ERASE_US)) u_ers (
        .clk(clk), .rst(rst), .load(ers_load), .tick(us_tick), .expire(ers_exp)
    );

    ewc_sector_set #(.NUM_SECT(NUM_SECT)) u_set (
        .clk(clk), .rst(rst), .add(mask_add), .idx(cmd_sector),
        .clr(mask_clr), .mask(pend_mask)
    );

    // Next-state and datapath control.
    always_comb begin
        state_d  = state_q;
        win_load = 1'b0;
        ers_load = 1'b0;
        mask_add = 1'b0;
        mask_clr = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (se_cmd) begin
                    state_d  = ST_COLLECT;
                    win_load = 1'b1;
                    mask_add = 1'b1;
                end
            end
            ST_COLLECT: begin
                if (se_cmd) begin
                    win_load = 1'b1;
                    mask_add = 1'b1;
                end else if (win_exp) begin
                    state_d  = ST_ERASE;
                    ers_load = 1'b1;
                end
            end
            ST_ERASE: begin
                if (ers_exp) begin
                    state_d  = ST_IDLE;
                    mask_clr = 1'b1;
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register.
    always_ff @(posedge clk) begin
        if (rst)
            state_q <= ST_IDLE;
        else
            state_q <= state_d;
    end

    // Registered outputs, decoded from the next state.
    always_ff @(posedge clk) begin
        if (rst) begin
            win_closed  <= 1'b0;
            busy        <= 1'b0;
            erase_start <= 1'b0;
            susp_out    <= 1'b0;
        end else begin
            win_closed  <= (state_d == ST_ERASE);
            busy        <= (state_d != ST_IDLE);
            erase_start <= ers_load;
            susp_out    <= (state_q == ST_ERASE) && su_cmd && !ers_exp;
        end
    end
endmodule

// File: rtl/erase_window_chk.sv
module erase_window_chk #(
    parameter int NUM_SECT = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                cmd_valid,
    input logic [1:0]          cmd_op,
    input logic                win_closed,
    input logic [NUM_SECT-1:0] pend_mask,
    input logic                erase_start,
    input logic                busy,
    input logic                susp_out
);
    // R3
    erase_start_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        erase_start |-> (win_closed && !$past(win_closed)) ##1 !erase_start);

    // R3
    closed_busy_chk: assert property (@(posedge clk) disable iff (rst)
        win_closed |-> busy);

    // R4
    restart_open_chk: assert property (@(posedge clk) disable iff (rst)
        (cmd_valid && cmd_op == 2'b01 && busy && !win_closed) |=> !win_closed);

    // R6
    mask_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        (win_closed && $past(win_closed)) |-> $stable(pend_mask));

    // R7
    susp_in_erase_chk: assert property (@(posedge clk) disable iff (rst)
        susp_out |-> $past(win_closed));

    // R8
    idle_clear_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (pend_mask == '0 && !win_closed));

    // R2
    busy_mask_chk: assert property (@(posedge clk) disable iff (rst)
        busy |-> (pend_mask != '0));
endmodule

bind erase_window_ctrl erase_window_chk #(.NUM_SECT(NUM_SECT)) u_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .win_closed(win_closed), .pend_mask(pend_mask), .erase_start(erase_start),
    .busy(busy), .susp_out(susp_out)
);

// File: tb/sim_erase_window_ctrl.sv
`timescale 1ns/1ps
module sim_erase_window_ctrl;
    localparam int WIN = 80;
    localparam int ERS = 16;
    localparam logic [1:0] SE = 2'b01, SU = 2'b10, CE = 2'b11;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cmd_valid = 1'b0;
    logic [1:0] cmd_op = 2'b00;
    logic [2:0] cmd_sector = 3'd0;
    logic       us_tick = 1'b0;
    logic       win_closed, erase_start, busy, susp_out;
    logic [7:0] pend_mask;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;

    always #2 clk = ~clk;

    erase_window_ctrl u0 (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_sector(cmd_sector), .us_tick(us_tick), .win_closed(win_closed),
        .pend_mask(pend_mask), .erase_start(erase_start), .busy(busy),
        .susp_out(susp_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    // Outputs packed as {susp, start, busy, closed, mask}.
    function automatic int outs();
        return {susp_out, erase_start, busy, win_closed, pend_mask};
    endfunction

    function automatic int pack(input bit su, input bit st, input bit bz,
                                input bit cl, input logic [7:0] m);
        return {su, st, bz, cl, m};
    endfunction

    task automatic cyc(input logic t, input logic v, input logic [1:0] op,
                       input logic [2:0] s);
        us_tick = t; cmd_valid = v; cmd_op = op; cmd_sector = s;
        @(posedge clk); #1;
        us_tick = 1'b0; cmd_valid = 1'b0; cmd_op = 2'b00;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b0, 2'b00, 3'd0);
    endtask

    task automatic cmd(input logic [1:0] op, input logic [2:0] s);
        cyc(1'b0, 1'b1, op, s);
    endtask

    task automatic t_reset();
        chk("R1 reset outputs", outs(), pack(0, 0, 0, 0, 8'h00));
    endtask

    task automatic t_single();
        cmd(SE, 3'd2);
        chk("R2 open", outs(), pack(0, 0, 1, 0, 8'h04));
        ticks(WIN - 1);
        chk("R3 one tick before close", outs(), pack(0, 0, 1, 0, 8'h04));
        ticks(1);
        chk("R3 close and start", outs(), pack(0, 1, 1, 1, 8'h04));
        cyc(1'b0, 1'b0, 2'b00, 3'd0);
        chk("R3 start one cycle", outs(), pack(0, 0, 1, 1, 8'h04));
        ticks(ERS - 1);
        chk("R8 still erasing", outs(), pack(0, 0, 1, 1, 8'h04));
        ticks(1);
        chk("R8 erase done", outs(), pack(0, 0, 0, 0, 8'h00));
    endtask

    task automatic t_accumulate();
        cmd(SE, 3'd0);
        ticks(49);
        cmd(SE, 3'd5);
        chk("R4 add sector", outs(), pack(0, 0, 1, 0, 8'h21));
        ticks(49);
        cmd(SE, 3'd0);
        chk("R5 duplicate unchanged", outs(), pack(0, 0, 1, 0, 8'h21));
        ticks(WIN - 1);
        chk("R5 duplicate restarted window", outs(), pack(0, 0, 1, 0, 8'h21));
        ticks(1);
        chk("R4 close after restart", outs(), pack(0, 1, 1, 1, 8'h21));
        ticks(ERS);
        chk("R8 drain", outs(), pack(0, 0, 0, 0, 8'h00));
    endtask

    task automatic t_ignore();
        cmd(SE, 3'd1);
        ticks(WIN);
        chk("R3 closed", outs(), pack(0, 1, 1, 1, 8'h02));
        cmd(SE, 3'd7);
        chk("R6 sector erase ignored", outs(), pack(0, 0, 1, 1, 8'h02));
        cmd(CE, 3'd4);
        chk("R6 chip erase ignored", outs(), pack(0, 0, 1, 1, 8'h02));
        cmd(SU, 3'd0);
        chk("R7 suspend pulse", outs(), pack(1, 0, 1, 1, 8'h02));
        cyc(1'b0, 1'b0, 2'b00, 3'd0);
        chk("R7 suspend one cycle", outs(), pack(0, 0, 1, 1, 8'h02));
        ticks(ERS - 1);
        chk("R6 erase length kept", outs(), pack(0, 0, 1, 1, 8'h02));
        ticks(1);
        chk("R8 done after ignored cmds", outs(), pack(0, 0, 0, 0, 8'h00));
    endtask

    task automatic t_idle_cmds();
        cmd(CE, 3'd4);
        chk("R9 chip erase no window", outs(), pack(0, 0, 0, 0, 8'h00));
        ticks(WIN + 5);
        chk("R9 still idle", outs(), pack(0, 0, 0, 0, 8'h00));
        cmd(SU, 3'd0);
        chk("R7 suspend in idle", outs(), pack(0, 0, 0, 0, 8'h00));
    endtask

    task automatic t_no_tick();
        cmd(SE, 3'd3);
        for (int i = 0; i < 30; i++) cyc(1'b0, 1'b0, 2'b00, 3'd0);
        ticks(WIN - 1);
        chk("R3 idle cycles not counted", outs(), pack(0, 0, 1, 0, 8'h08));
        ticks(1);
        chk("R3 close on tick count", outs(), pack(0, 1, 1, 1, 8'h08));
        ticks(ERS);
        chk("R8 drain", outs(), pack(0, 0, 0, 0, 8'h00));
    endtask

    task automatic t_mid_reset();
        cmd(SE, 3'd6);
        ticks(10);
        rst = 1'b1;
        cyc(1'b0, 1'b0, 2'b00, 3'd0);
        rst = 1'b0;
        chk("R10 reset clears", outs(), pack(0, 0, 0, 0, 8'h00));
        ticks(WIN + ERS);
        chk("R10 no late erase", outs(), pack(0, 0, 0, 0, 8'h00));
    endtask

    task automatic finish_run();
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 50000) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d cycles expected fewer", n_cyc);
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        t_reset();
        rst = 1'b0;
        t_single();
        t_accumulate();
        t_ignore();
        t_idle_cmds();
        t_no_tick();
        t_mid_reset();
        finish_run();
    end
endmodule